// File: doc/BRIEF.md
# Program Counter Next-Address Selector

This block holds the 12-bit program counter of a small 8-bit controller core and picks, every clock, which of seven sources becomes the next instruction address. The instruction decoder presents a 3-bit class code together with a jump or call target, a signed 8-bit branch displacement, the address popped from the return stack and a flag that says whether that stack is empty. The interrupt controller presents an entry request and its vector. The reset vector comes in as a plain input, so the integration decides where execution starts.

The combinational next address is available on `pc_nxt` before the edge. The registered address on `pc_q` is the address being fetched, and it is the value a call pushes onto the return stack. The program space is 4096 bytes, so every sum wraps at 12 bits. Bank switching beyond that range, fetch, decode and the general ALU belong to other blocks.

Top module: `pc_next_sel`

## Requirements
- R1: While `rst_n` is low, `pc_nxt` equals `rst_vec` whatever the other inputs are, and the next rising edge loads `rst_vec` into `pc_q`. Reset outranks every other source.
- R2: With `rst_n` high and `irq_take` high, the next PC is `irq_vec`, whatever `op` and the other inputs are.
- R3: With no interrupt, `op` = 0 (sequential) advances the PC to `pc_q` + 1. The codes 6 and 7 are unused and behave the same way.
- R4: With no interrupt, `op` = 1 (jump) and `op` = 2 (call) both load `tgt` into the PC.
- R5: With no interrupt, `op` = 3 (relative branch) loads `pc_q` + 1 + sign-extended `ofs`. The displacement is relative to the already incremented address and covers -128 to +127.
- R6: With no interrupt, `op` = 4 (return) and `op` = 5 (return from interrupt) load `pop_addr` when `stk_empty` is low.
- R7: A return or return from interrupt with `stk_empty` high ignores `pop_addr` and advances to `pc_q` + 1.
- R8: All next-PC arithmetic wraps modulo 4096. 0xFFF + 1 gives 0x000, and a branch across either end of the space wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC register updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rst_vec | input | 12 | Address loaded on reset |
| irq_take | input | 1 | Interrupt entry this cycle |
| irq_vec | input | 12 | Interrupt entry address |
| op | input | 3 | Instruction class: 0 sequential, 1 jump, 2 call, 3 branch, 4 return, 5 return from interrupt |
| tgt | input | 12 | Jump or call destination |
| ofs | input | 8 | Signed branch displacement, two's complement |
| pop_addr | input | 12 | Top of the return stack |
| stk_empty | input | 1 | Return stack holds no entry |
| pc_nxt | output | 12 | Combinational next PC |
| pc_q | output | 12 | Current PC, the value a call pushes |

## Verification
The embedded properties check the register transition on every cycle out of reset. They cover the reset load, interrupt precedence, the sequential step, jump and call loading, returns through the stack, and the empty-stack fallback. Branch arithmetic at the displacement limits and wrap-around at both ends of the 4096-byte space only show up in the bench's scenarios. The same holds for unused class codes and for reset asserted together with an interrupt and a jump. In those scenarios the bench predicts each address by hand and compares both `pc_nxt` before the edge and `pc_q` after it.

// File: rtl/pc_next_sel.sv
module pc_next_sel #(
  parameter int AW = 12,
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rst_vec,
  input  logic          irq_take,
  input  logic [AW-1:0] irq_vec,
  input  logic [2:0]    op,
  input  logic [AW-1:0] tgt,
  input  logic [OW-1:0] ofs,
  input  logic [AW-1:0] pop_addr,
  input  logic          stk_empty,
  output logic [AW-1:0] pc_nxt,
  output logic [AW-1:0] pc_q
);

  localparam logic [2:0] OP_SEQ  = 3'd0;
  localparam logic [2:0] OP_JMP  = 3'd1;
  localparam logic [2:0] OP_CALL = 3'd2;
  localparam logic [2:0] OP_BRA  = 3'd3;
  localparam logic [2:0] OP_RET  = 3'd4;
  localparam logic [2:0] OP_RETI = 3'd5;

  logic [AW-1:0] inc;
  logic [AW-1:0] ofs_x;
  logic [AW-1:0] sel;

  assign inc   = pc_q + AW'(1);
  assign ofs_x = {{(AW-OW){ofs[OW-1]}}, ofs};

  always_comb begin
    case (op)
      OP_JMP, OP_CALL: sel = tgt;
      OP_BRA:          sel = inc + ofs_x;
      OP_RET, OP_RETI: sel = stk_empty ? inc : pop_addr;
      default:         sel = inc;
    endcase
  end

  assign pc_nxt = !rst_n ? rst_vec : (irq_take ? irq_vec : sel);

  always_ff @(posedge clk) pc_q <= pc_nxt;

  a_r1_reset_load: assert property (@(posedge clk)
    !rst_n |=> pc_q == $past(rst_vec));

  a_r2_irq_wins: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> pc_q == $past(irq_vec));

  a_r3_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_take && op == OP_SEQ) |=> pc_q == AW'($past(pc_q) + AW'(1)));

  a_r4_jump_call: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_take && (op == OP_JMP || op == OP_CALL)) |=> pc_q == $past(tgt));

  a_r6_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_take && (op == OP_RET || op == OP_RETI) && !stk_empty)
      |=> pc_q == $past(pop_addr));

  a_r7_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_take && (op == OP_RET || op == OP_RETI) && stk_empty)
      |=> pc_q == AW'($past(pc_q) + AW'(1)));

endmodule

// File: tb/pc_next_sel_tb.sv
module pc_next_sel_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] rst_vec, irq_vec, tgt, pop_addr;
  logic        irq_take, stk_empty;
  logic [2:0]  op;
  logic [7:0]  ofs;
  logic [11:0] pc_nxt, pc_q;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  pc_next_sel u_dut (
    .clk(clk), .rst_n(rst_n), .rst_vec(rst_vec), .irq_take(irq_take),
    .irq_vec(irq_vec), .op(op), .tgt(tgt), .ofs(ofs), .pop_addr(pop_addr),
    .stk_empty(stk_empty), .pc_nxt(pc_nxt), .pc_q(pc_q)
  );

  // [60] irq, [59:57] op, [56:45] tgt, [44:37] ofs, [36:25] pop, [24] empty,
  // [23:12] irq vector, [11:0] expected next PC
  localparam int N = 16;
  localparam logic [60:0] TBL [0:N-1] = '{
    {1'b0, 3'd0, 12'h000, 8'h00, 12'h000, 1'b0, 12'h000, 12'h101}, // R3
    {1'b0, 3'd1, 12'h3F0, 8'h00, 12'h000, 1'b0, 12'h000, 12'h3F0}, // R4 jump
    {1'b0, 3'd3, 12'h000, 8'h05, 12'h000, 1'b0, 12'h000, 12'h3F6}, // R5 +5
    {1'b0, 3'd3, 12'h000, 8'hF8, 12'h000, 1'b0, 12'h000, 12'h3EF}, // R5 -8
    {1'b0, 3'd2, 12'hFFE, 8'h00, 12'h000, 1'b0, 12'h000, 12'hFFE}, // R4 call
    {1'b0, 3'd0, 12'h000, 8'h00, 12'h000, 1'b0, 12'h000, 12'hFFF}, // R3
    {1'b0, 3'd0, 12'h000, 8'h00, 12'h000, 1'b0, 12'h000, 12'h000}, // R8 wrap
    {1'b0, 3'd3, 12'h000, 8'hFF, 12'h000, 1'b0, 12'h000, 12'h000}, // R5 -1
    {1'b0, 3'd3, 12'h000, 8'h80, 12'h000, 1'b0, 12'h000, 12'hF81}, // R8 -128 wrap
    {1'b0, 3'd4, 12'h000, 8'h00, 12'h234, 1'b0, 12'h000, 12'h234}, // R6 return
    {1'b0, 3'd5, 12'h000, 8'h00, 12'h555, 1'b1, 12'h000, 12'h235}, // R7 empty
    {1'b1, 3'd1, 12'h777, 8'h00, 12'h000, 1'b0, 12'h010, 12'h010}, // R2 irq
    {1'b0, 3'd5, 12'h000, 8'h00, 12'hABC, 1'b0, 12'h000, 12'hABC}, // R6 reti
    {1'b0, 3'd7, 12'h000, 8'h00, 12'h000, 1'b0, 12'h000, 12'hABD}, // R3 unused
    {1'b0, 3'd3, 12'h000, 8'h7F, 12'h000, 1'b0, 12'h000, 12'hB3D}, // R5 +127
    {1'b0, 3'd1, 12'h001, 8'h00, 12'h999, 1'b0, 12'h000, 12'h001}  // R4
  };

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    irq_take = 1'b0; op = 3'd0; tgt = '0; ofs = '0;
    pop_addr = '0; stk_empty = 1'b0; irq_vec = '0;
  endtask

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rst_vec = 12'h100; idle();
    @(posedge clk); @(posedge clk); #1;
    check("R1 reset state", pc_q, 12'h100);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < N; i++) begin
      irq_take  = TBL[i][60];
      op        = TBL[i][59:57];
      tgt       = TBL[i][56:45];
      ofs       = TBL[i][44:37];
      pop_addr  = TBL[i][36:25];
      stk_empty = TBL[i][24];
      irq_vec   = TBL[i][23:12];
      #1 check("R2-R8 pc_nxt", pc_nxt, TBL[i][11:0]);
      @(posedge clk); #1;
      check("R2-R8 pc_q", pc_q, TBL[i][11:0]);
      @(negedge clk);
    end

    // R1: reset outranks an interrupt and a jump
    rst_vec = 12'h2A0; rst_n = 1'b0;
    irq_take = 1'b1; irq_vec = 12'h040; op = 3'd1; tgt = 12'h555;
    #1 check("R1 pc_nxt priority", pc_nxt, 12'h2A0);
    @(posedge clk); #1;
    check("R1 pc_q priority", pc_q, 12'h2A0);
    @(negedge clk); rst_n = 1'b1; idle();

    // R7: return with empty stack and unused code 6 (R3)
    op = 3'd4; stk_empty = 1'b1; pop_addr = 12'hFED;
    @(posedge clk); #1;
    check("R7 empty ret", pc_q, 12'h2A1);
    @(negedge clk); op = 3'd6; stk_empty = 1'b0;
    @(posedge clk); #1;
    check("R3 code 6", pc_q, 12'h2A2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule